// File: doc/BRIEF.md
# Bridging Buffer Descriptor Sequencer

This block keeps a small ring of buffer descriptors that sits between a cell-receive path and a serial transmit path. Each incoming byte strobe is counted against the descriptor currently being filled. When the count reaches the programmed buffer length, the descriptor is closed. Its ready flag is then raised, not cleared: this ring runs with inverted ownership polarity, so a set flag means the buffer is full and belongs to the transmitter. If the descriptor asks for it, a sticky interrupt flag is also raised.

The serial transmitter takes full descriptors in ring order. It stays idle until two things have happened: the descriptor chosen by an arm command has closed, and a start command has followed. That pre-fill absorbs cell delay variation before forwarding begins. Two transmit channels are supervised: the serial one, which reads this ring, and a cell transmit channel whose descriptor readiness comes in on a pin. Either channel stops when it meets a descriptor that is not ready. It stays stopped until its own restart pulse. Each stop raises its own sticky status flag, and all flags clear by writing 1.

Top module: `bridge_bd_seq`

## Requirements
- R1: After reset every descriptor has ready, wrap and interrupt bits at 0 and count 0. The fill index, transmit index, all status flags, both halt states, both acknowledges and the serial run state are 0.
- R2: A byte strobe taken into a not-ready descriptor advances its fill count. On the byte that brings the count to `bufLen` (nonzero), the descriptor gets ready=1 and count=`bufLen`, and the fill index moves on one cycle later.
- R3: A ring index moves to 0 after an entry whose wrap bit is set, and after entry DEPTH-1. Otherwise it moves to the next entry.
- R4: Closing a descriptor whose interrupt bit is set raises `irq` on the next cycle. Closing one with the bit clear leaves `irq` unchanged. `irq` stays set until cleared.
- R5: A byte strobe that finds the current fill descriptor ready=1 is dropped. The fill index, the fill count and the descriptor contents do not change.
- R6: Serial requests are ignored until `serRun` is set. `serRun` is set by `startCmd` only after the descriptor named by the last `armCmd` (entry 0 after reset) has closed. A `startCmd` before that is ignored.
- R7: A serial request while running and not halted, at a ready descriptor, clears that descriptor's ready bit, advances the transmit index, and pulses `serAck` for one cycle on the next cycle.
- R8: A serial request at a not-ready descriptor sets `serHalted` and the serial halt flag. While halted, requests are ignored. `serRestart` clears the halted state.
- R9: A cell request while not halted pulses `cellAck` if `cellBdReady` is 1. Otherwise it sets `cellHalted` and the cell halt flag. Requests are ignored while halted until `cellRestart`.
- R10: A descriptor write sets the wrap and interrupt bits as given and clears ready and count. It takes priority over a close or consume at the same entry.
- R11: Writing 1 to `statusClr` bit 0 clears `irq`, bit 1 clears the serial halt flag, and bit 2 clears the cell halt flag, each independently. A new set event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bufLen | input | CNT_W | Bytes per buffer |
| rxValid | input | 1 | One incoming byte this cycle |
| bdWrEn | input | 1 | Descriptor write strobe |
| bdWrIdx | input | IDX_W | Descriptor to write |
| bdWrWrap | input | 1 | Wrap bit to write |
| bdWrIntEn | input | 1 | Interrupt bit to write |
| rdIdx | input | IDX_W | Descriptor to observe |
| rdReady | output | 1 | Ready bit of observed descriptor |
| rdWrap | output | 1 | Wrap bit of observed descriptor |
| rdIntEn | output | 1 | Interrupt bit of observed descriptor |
| rdCount | output | CNT_W | Byte count of observed descriptor |
| armCmd | input | 1 | Select the descriptor that gates the serial start |
| armIdx | input | IDX_W | Gating descriptor index |
| startCmd | input | 1 | Start serial transmitter |
| serReq | input | 1 | Serial transmitter wants a buffer |
| serRestart | input | 1 | Restart halted serial channel |
| serAck | output | 1 | Serial buffer handed over |
| serRun | output | 1 | Serial transmitter started |
| serHalted | output | 1 | Serial channel halted |
| cellReq | input | 1 | Cell transmitter wants a buffer |
| cellBdReady | input | 1 | Readiness of the cell transmit descriptor |
| cellRestart | input | 1 | Restart halted cell channel |
| cellAck | output | 1 | Cell buffer accepted |
| cellHalted | output | 1 | Cell channel halted |
| statusClr | input | 3 | Write-1-to-clear for status flags |
| irq | output | 1 | Sticky interrupt flag |
| serHaltFlag | output | 1 | Sticky serial halt flag |
| cellHaltFlag | output | 1 | Sticky cell halt flag |
| fillIdx | output | IDX_W | Descriptor being filled |
| txIdx | output | IDX_W | Next descriptor for serial transmit |

## Verification
The bench uses the default DEPTH of 8 and a count width of 8. Buffer lengths are short, 3 or 4 bytes, so the fill side goes round the ring many times within a few thousand cycles. Directed passes use a wrap bit at entry 5 to cut the ring to six entries, which exercises the wrap-bit return. A later reprogram with no wrap bits exercises the return after entry 7. The fill side catches up with unconsumed buffers, so dropped bytes and serial halts both occur often.

// File: rtl/bbs_pkg.sv
`timescale 1ns/1ps
package bbs_pkg;
  typedef struct packed {
    logic closeEn;
    logic consumeEn;
  } ringStrobe_t;

  localparam int unsigned ST_INT  = 0;
  localparam int unsigned ST_SER  = 1;
  localparam int unsigned ST_CELL = 2;
endpackage

// File: rtl/bbs_ring.sv
`timescale 1ns/1ps
module bbs_ring
  import bbs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bdWrEn,
  input  logic [IDX_W-1:0] bdWrIdx,
  input  logic             bdWrWrap,
  input  logic             bdWrIntEn,
  input  ringStrobe_t      stb,
  input  logic [CNT_W-1:0] closeCount,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [IDX_W-1:0] txIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             fillReady,
  output logic             fillWrap,
  output logic             fillInt,
  output logic             txReady,
  output logic             txWrap,
  output logic             rdReady,
  output logic             rdWrap,
  output logic             rdIntEn,
  output logic [CNT_W-1:0] rdCount
);
  logic [DEPTH-1:0] readyQ;
  logic [DEPTH-1:0] wrapQ;
  logic [DEPTH-1:0] intQ;
  logic [CNT_W-1:0] countQ [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '0;
      wrapQ  <= '0;
      intQ   <= '0;
      for (int e = 0; e < DEPTH; e++) countQ[e] <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (bdWrEn && bdWrIdx == IDX_W'(e)) begin
          readyQ[e] <= 1'b0;
          countQ[e] <= '0;
          wrapQ[e]  <= bdWrWrap;
          intQ[e]   <= bdWrIntEn;
        end else begin
          if (stb.closeEn && fillIdx == IDX_W'(e)) begin
            readyQ[e] <= 1'b1;
            countQ[e] <= closeCount;
          end
          if (stb.consumeEn && txIdx == IDX_W'(e)) readyQ[e] <= 1'b0;
        end
      end
    end
  end

  assign fillReady = readyQ[fillIdx];
  assign fillWrap  = wrapQ[fillIdx];
  assign fillInt   = intQ[fillIdx];
  assign txReady   = readyQ[txIdx];
  assign txWrap    = wrapQ[txIdx];
  assign rdReady   = readyQ[rdIdx];
  assign rdWrap    = wrapQ[rdIdx];
  assign rdIntEn   = intQ[rdIdx];
  assign rdCount   = countQ[rdIdx];
endmodule

// File: rtl/bbs_ctrl.sv
`timescale 1ns/1ps
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] bufLen,
  input  logic             rxValid,
  input  logic             fillReady,
  input  logic             fillWrap,
  input  logic             fillInt,
  input  logic             txReady,
  input  logic             txWrap,
  input  logic             armCmd,
  input  logic [IDX_W-1:0] armIdx,
  input  logic             startCmd,
  input  logic             serReq,
  input  logic             serRestart,
  input  logic             cellReq,
  input  logic             cellBdReady,
  input  logic             cellRestart,
  input  logic [2:0]       statusClr,
  output ringStrobe_t      stb,
  output logic [CNT_W-1:0] closeCount,
  output logic [IDX_W-1:0] fillIdx,
  output logic [IDX_W-1:0] txIdx,
  output logic             serAck,
  output logic             serRun,
  output logic             serHalted,
  output logic             cellAck,
  output logic             cellHalted,
  output logic             irq,
  output logic             serHaltFlag,
  output logic             cellHaltFlag
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [CNT_W-1:0] fillCnt;
  logic [CNT_W-1:0] cntInc;
  logic [IDX_W-1:0] targetIdx;
  logic             primed;
  logic             byteTaken, closeHit;
  logic             serGo, serTake, serStall;
  logic             cellGo, cellTake, cellStall;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] cur, input logic wrap);
    if (wrap || cur == LAST_IDX) return '0;
    return cur + 1'b1;
  endfunction

  always_comb begin
    cntInc    = fillCnt + 1'b1;
    byteTaken = rxValid && !fillReady;
    closeHit  = byteTaken && (cntInc >= bufLen);
    serGo     = serReq && serRun && !serHalted && !serRestart;
    serTake   = serGo && txReady;
    serStall  = serGo && !txReady;
    cellGo    = cellReq && !cellHalted && !cellRestart;
    cellTake  = cellGo && cellBdReady;
    cellStall = cellGo && !cellBdReady;
    stb.closeEn   = closeHit;
    stb.consumeEn = serTake;
    closeCount    = cntInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt      <= '0;
      fillIdx      <= '0;
      txIdx        <= '0;
      serAck       <= 1'b0;
      cellAck      <= 1'b0;
      serHalted    <= 1'b0;
      cellHalted   <= 1'b0;
      irq          <= 1'b0;
      serHaltFlag  <= 1'b0;
      cellHaltFlag <= 1'b0;
      targetIdx    <= '0;
      primed       <= 1'b0;
      serRun       <= 1'b0;
    end else begin
      if (byteTaken) begin
        if (closeHit) begin
          fillCnt <= '0;
          fillIdx <= stepIdx(fillIdx, fillWrap);
        end else begin
          fillCnt <= cntInc;
        end
      end
      if (serTake) txIdx <= stepIdx(txIdx, txWrap);
      serAck  <= serTake;
      cellAck <= cellTake;

      if (serRestart)    serHalted <= 1'b0;
      else if (serStall) serHalted <= 1'b1;
      if (cellRestart)    cellHalted <= 1'b0;
      else if (cellStall) cellHalted <= 1'b1;

      irq          <= (irq & ~statusClr[ST_INT]) | (closeHit & fillInt);
      serHaltFlag  <= (serHaltFlag & ~statusClr[ST_SER]) | serStall;
      cellHaltFlag <= (cellHaltFlag & ~statusClr[ST_CELL]) | cellStall;

      if (armCmd) begin
        targetIdx <= armIdx;
        primed    <= 1'b0;
      end else if (closeHit && fillIdx == targetIdx) begin
        primed <= 1'b1;
      end
      if (startCmd && primed) serRun <= 1'b1;
    end
  end
endmodule

// File: rtl/bridge_bd_seq.sv
`timescale 1ns/1ps
module bridge_bd_seq
  import bbs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 8,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] bufLen,
  input  logic             rxValid,
  input  logic             bdWrEn,
  input  logic [IDX_W-1:0] bdWrIdx,
  input  logic             bdWrWrap,
  input  logic             bdWrIntEn,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdReady,
  output logic             rdWrap,
  output logic             rdIntEn,
  output logic [CNT_W-1:0] rdCount,
  input  logic             armCmd,
  input  logic [IDX_W-1:0] armIdx,
  input  logic             startCmd,
  input  logic             serReq,
  input  logic             serRestart,
  output logic             serAck,
  output logic             serRun,
  output logic             serHalted,
  input  logic             cellReq,
  input  logic             cellBdReady,
  input  logic             cellRestart,
  output logic             cellAck,
  output logic             cellHalted,
  input  logic [2:0]       statusClr,
  output logic             irq,
  output logic             serHaltFlag,
  output logic             cellHaltFlag,
  output logic [IDX_W-1:0] fillIdx,
  output logic [IDX_W-1:0] txIdx
);
  ringStrobe_t      stb;
  logic [CNT_W-1:0] closeCount;
  logic             fillReady, fillWrap, fillInt, txReady, txWrap;

  bbs_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .bufLen(bufLen), .rxValid(rxValid),
    .fillReady(fillReady), .fillWrap(fillWrap), .fillInt(fillInt),
    .txReady(txReady), .txWrap(txWrap),
    .armCmd(armCmd), .armIdx(armIdx), .startCmd(startCmd),
    .serReq(serReq), .serRestart(serRestart),
    .cellReq(cellReq), .cellBdReady(cellBdReady), .cellRestart(cellRestart),
    .statusClr(statusClr), .stb(stb), .closeCount(closeCount),
    .fillIdx(fillIdx), .txIdx(txIdx),
    .serAck(serAck), .serRun(serRun), .serHalted(serHalted),
    .cellAck(cellAck), .cellHalted(cellHalted),
    .irq(irq), .serHaltFlag(serHaltFlag), .cellHaltFlag(cellHaltFlag)
  );

  bbs_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) uRing (
    .clk(clk), .rstN(rstN),
    .bdWrEn(bdWrEn), .bdWrIdx(bdWrIdx), .bdWrWrap(bdWrWrap), .bdWrIntEn(bdWrIntEn),
    .stb(stb), .closeCount(closeCount),
    .fillIdx(fillIdx), .txIdx(txIdx), .rdIdx(rdIdx),
    .fillReady(fillReady), .fillWrap(fillWrap), .fillInt(fillInt),
    .txReady(txReady), .txWrap(txWrap),
    .rdReady(rdReady), .rdWrap(rdWrap), .rdIntEn(rdIntEn), .rdCount(rdCount)
  );
endmodule

// File: rtl/bbs_checker.sv
`timescale 1ns/1ps
module bbs_checker #(
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             serReq,
  input logic             serRestart,
  input logic             cellRestart,
  input logic [2:0]       statusClr,
  input logic             irq,
  input logic             serAck,
  input logic             serRun,
  input logic             serHalted,
  input logic             cellAck,
  input logic             cellHalted,
  input logic [IDX_W-1:0] fillIdx,
  input logic [IDX_W-1:0] txIdx
);
  AST_FILL_STEADY: assert property (@(posedge clk) disable iff (!rstN) !rxValid |=> $stable(fillIdx)); // R2
  AST_TX_STEADY: assert property (@(posedge clk) disable iff (!rstN) !serReq |=> $stable(txIdx)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN) (irq && !statusClr[0]) |=> irq); // R4
  AST_ACK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN) serAck |-> serRun); // R6
  AST_SER_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (serHalted && !serRestart) |=> (serHalted && !serAck)); // R8
  AST_CELL_HALT_HOLD: assert property (@(posedge clk) disable iff (!rstN) (cellHalted && !cellRestart) |=> (cellHalted && !cellAck)); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN) (serAck && !serReq) |=> !serAck); // R7
endmodule

bind bridge_bd_seq bbs_checker #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .serReq(serReq),
  .serRestart(serRestart), .cellRestart(cellRestart), .statusClr(statusClr),
  .irq(irq), .serAck(serAck), .serRun(serRun), .serHalted(serHalted),
  .cellAck(cellAck), .cellHalted(cellHalted), .fillIdx(fillIdx), .txIdx(txIdx)
);

// File: tb/bridge_bd_seq_test.sv
`timescale 1ns/1ps
module bridge_bd_seq_test;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] bufLen = 8'd4;
  logic rxValid = 0, bdWrEn = 0, bdWrWrap = 0, bdWrIntEn = 0;
  logic [IDX_W-1:0] bdWrIdx = '0, rdIdx = '0, armIdx = '0;
  logic armCmd = 0, startCmd = 0, serReq = 0, serRestart = 0;
  logic cellReq = 0, cellBdReady = 0, cellRestart = 0;
  logic [2:0] statusClr = '0;
  logic rdReady, rdWrap, rdIntEn, serAck, serRun, serHalted, cellAck, cellHalted;
  logic irq, serHaltFlag, cellHaltFlag;
  logic [CNT_W-1:0] rdCount;
  logic [IDX_W-1:0] fillIdx, txIdx;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int mReady[DEPTH], mWrap[DEPTH], mInt[DEPTH], mCount[DEPTH];
  int mFill, mTx, mCnt, mTarget, mPrimed, mSerRun;
  int mIrq, mSerF, mCellF, mSerH, mCellH, mSerAck, mCellAck;

  always #4 clk = ~clk;

  bridge_bd_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) uut (.*);

  function automatic int nxt(input int i);
    return (mWrap[i] != 0 || i == DEPTH - 1) ? 0 : i + 1;
  endfunction

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) begin
      mReady[i] = 0; mWrap[i] = 0; mInt[i] = 0; mCount[i] = 0;
    end
    mFill = 0; mTx = 0; mCnt = 0; mTarget = 0; mPrimed = 0; mSerRun = 0;
    mIrq = 0; mSerF = 0; mCellF = 0; mSerH = 0; mCellH = 0; mSerAck = 0; mCellAck = 0;
  endtask

  task automatic compareOuts(input string tag);
    chk(tag, "fillIdx", int'(fillIdx), mFill);
    chk(tag, "txIdx", int'(txIdx), mTx);
    chk(tag, "irq", int'(irq), mIrq);
    chk(tag, "serAck", int'(serAck), mSerAck);
    chk(tag, "serRun", int'(serRun), mSerRun);
    chk(tag, "serHalted", int'(serHalted), mSerH);
    chk(tag, "serHaltFlag", int'(serHaltFlag), mSerF);
    chk(tag, "cellAck", int'(cellAck), mCellAck);
    chk(tag, "cellHalted", int'(cellHalted), mCellH);
    chk(tag, "cellHaltFlag", int'(cellHaltFlag), mCellF);
  endtask

  task automatic tick(input string tag);
    int rf, rt, closeIt, takeIt, nFill, nTx, nCnt, irqSet, primeHit, serSet, cellSet, c;
    int nSerH, nCellH, nSerAck, nCellAck;
    rf = mReady[mFill]; rt = mReady[mTx];
    closeIt = 0; takeIt = 0; irqSet = 0; primeHit = 0; serSet = 0; cellSet = 0;
    nFill = mFill; nTx = mTx; nCnt = mCnt; c = 0;
    nSerH = mSerH; nCellH = mCellH; nSerAck = 0; nCellAck = 0;
    if (rxValid && rf == 0) begin
      c = mCnt + 1;
      if (c >= int'(bufLen)) begin
        closeIt = 1; irqSet = mInt[mFill]; primeHit = (mFill == mTarget);
        nFill = nxt(mFill); nCnt = 0;
      end else nCnt = c;
    end
    if (serRestart) nSerH = 0;
    else if (serReq && mSerRun != 0 && mSerH == 0) begin
      if (rt != 0) begin takeIt = 1; nTx = nxt(mTx); nSerAck = 1; end
      else begin nSerH = 1; serSet = 1; end
    end
    if (cellRestart) nCellH = 0;
    else if (cellReq && mCellH == 0) begin
      if (cellBdReady) nCellAck = 1;
      else begin nCellH = 1; cellSet = 1; end
    end
    @(posedge clk); #1;
    if (closeIt != 0) begin mReady[mFill] = 1; mCount[mFill] = c; end
    if (takeIt != 0) mReady[mTx] = 0;
    if (bdWrEn) begin
      mReady[bdWrIdx] = 0; mCount[bdWrIdx] = 0;
      mWrap[bdWrIdx] = bdWrWrap; mInt[bdWrIdx] = bdWrIntEn;
    end
    mIrq  = ((mIrq != 0 && !statusClr[0]) || irqSet != 0) ? 1 : 0;
    mSerF = ((mSerF != 0 && !statusClr[1]) || serSet != 0) ? 1 : 0;
    mCellF = ((mCellF != 0 && !statusClr[2]) || cellSet != 0) ? 1 : 0;
    if (startCmd && mPrimed != 0) mSerRun = 1;
    if (armCmd) begin mTarget = int'(armIdx); mPrimed = 0; end
    else if (primeHit != 0) mPrimed = 1;
    mFill = nFill; mTx = nTx; mCnt = nCnt;
    mSerH = nSerH; mCellH = nCellH; mSerAck = nSerAck; mCellAck = nCellAck;
    compareOuts(tag);
  endtask

  task automatic checkRing(input string tag);
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = IDX_W'(i);
      #0.5;
      chk(tag, "rdReady", int'(rdReady), mReady[i]);
      chk(tag, "rdWrap", int'(rdWrap), mWrap[i]);
      chk(tag, "rdIntEn", int'(rdIntEn), mInt[i]);
      chk(tag, "rdCount", int'(rdCount), mCount[i]);
    end
  endtask

  task automatic feed(input int n, input string tag);
    rxValid = 1;
    repeat (n) tick(tag);
    rxValid = 0;
  endtask

  task automatic writeBd(input int i, input bit w, input bit ie, input string tag);
    bdWrEn = 1; bdWrIdx = IDX_W'(i); bdWrWrap = w; bdWrIntEn = ie;
    tick(tag);
    bdWrEn = 0; bdWrWrap = 0; bdWrIntEn = 0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    compareOuts("R1");
    checkRing("R1");
    rstN = 1;
    tick("R1");

    // ring cut to six entries by the wrap bit on entry 5; interrupts on 1 and 3
    for (int i = 0; i < DEPTH; i++) writeBd(i, i == 5, i == 1 || i == 3, "R10");
    checkRing("R10");

    armCmd = 1; armIdx = 3'd2; tick("R6"); armCmd = 0;
    serReq = 1; tick("R6"); serReq = 0;
    startCmd = 1; tick("R6"); startCmd = 0;

    feed(3, "R2");
    checkRing("R2");
    feed(1, "R2");
    checkRing("R2");
    feed(4, "R4");
    tick("R4");
    statusClr = 3'b001; tick("R11"); statusClr = '0;
    feed(4, "R6");
    startCmd = 1; tick("R6"); startCmd = 0;
    tick("R6");

    serReq = 1;
    repeat (3) tick("R7");
    tick("R8");
    tick("R8");
    serReq = 0;
    serRestart = 1; tick("R8"); serRestart = 0;

    feed(12, "R3");
    feed(12, "R3");
    checkRing("R3");
    feed(5, "R5");
    checkRing("R5");

    cellReq = 1; cellBdReady = 1; tick("R9");
    cellBdReady = 0; tick("R9");
    tick("R9");
    cellReq = 0; tick("R9");
    serReq = 1; tick("R8"); serReq = 0;
    statusClr = 3'b100; tick("R11"); statusClr = '0;
    cellRestart = 1; tick("R9"); cellRestart = 0;
    cellReq = 1; cellBdReady = 1; tick("R9"); cellReq = 0;
    statusClr = 3'b010; tick("R11"); statusClr = '0;
    serRestart = 1; tick("R8"); serRestart = 0;

    // full eight-entry ring, no wrap bits
    for (int i = 0; i < DEPTH; i++) writeBd(i, 0, ($urandom % 2) != 0, "R10");
    bufLen = 8'd3;
    for (int k = 0; k < 4000; k++) begin
      rxValid     = ($urandom % 2) != 0;
      serReq      = ($urandom % 5) < 2;
      serRestart  = (mSerH != 0) && (($urandom % 4) == 0);
      cellReq     = ($urandom % 8) == 0;
      cellBdReady = ($urandom % 2) != 0;
      cellRestart = (mCellH != 0) && (($urandom % 3) == 0);
      statusClr   = (($urandom % 16) == 0) ? 3'($urandom) : 3'b000;
      tick((k % 2 == 0) ? "R7" : "R3");
    end
    rxValid = 0; serReq = 0; serRestart = 0; cellReq = 0; cellRestart = 0; statusClr = '0;
    tick("R7");
    checkRing("R3");

    finished = 1;
    summary();
    $finish;
  end
endmodule